// File: doc/BRIEF.md
# Undo-Logged Checkpoint Memory

This block wraps a small word-addressed data memory and gives it a single logical checkpoint through undo logging. Clients issue loads and stores on one request port. A checkpoint command marks the current memory contents as the recovery point. A rollback command returns the memory to those contents. The memory is never copied as a whole.

Each word has a flag that records whether it has already been saved in the current interval. The first store to a word after a checkpoint pushes the word's address and old value onto a log. Any later store to that word in the same interval pushes nothing. On rollback a sequencer pops the log from the newest entry to the oldest and writes one saved value back per clock, with busy held high while it runs. When the log is empty, the flags are cleared, so the restored contents become the new recovery point. The log has one entry per memory word, so it cannot overflow within an interval.

Top module: `ulog_ckpt_unit`

## Requirements
- R1: After reset every memory word reads 0, rsp_rdata is 0, busy is 0 and the log is empty.
- R2: A load accepted at a clock edge (req_valid=1, req_write=0) puts the word at req_addr on rsp_rdata after that edge. rsp_rdata then keeps its value until the next accepted load.
- R3: A store accepted at a clock edge (req_valid=1, req_write=1) writes req_wdata to req_addr. If that word has not been logged since the last checkpoint, its address and its value before the store are pushed onto the log.
- R4: A store to a word that has already been logged in the current interval adds no log entry. From an all-zero memory, the stores 3→0, 4→1, 5→0, 6→2 leave exactly three entries.
- R5: Rollback writes the saved values back from the newest entry to the oldest. Afterwards every word holds the value it had at the last checkpoint.
- R6: A checkpoint command accepted while idle clears every logged flag and empties the log in the same clock. Stores made before it are never undone.
- R7: busy rises after the edge that samples a rollback command while idle. It stays high for N cycles, where N is the number of log entries, and for 1 cycle when the log is empty.
- R8: While busy is high, loads, stores and checkpoint commands are ignored. They change no memory word, no log entry and no rsp_rdata.
- R9: When rollback ends, the log is empty and all flags are clear. A second rollback issued right after it lasts one cycle and changes nothing.
- R10: A store accepted in the same cycle as a checkpoint command belongs to the new interval, so it is logged, and a later rollback undoes it.
- R11: A rollback command has priority over a load, a store or a checkpoint command presented in the same cycle. Those are ignored.
- R12: The log holds one entry per memory word. Storing to every word in one interval, and then storing to every word again, is undone in full by a rollback that lasts 2^AW cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load or store request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| ckpt | input | 1 | Take a new checkpoint |
| rollback | input | 1 | Return memory to the checkpoint |
| rsp_rdata | output | DW | Data of the last accepted load |
| busy | output | 1 | Rollback in progress; requests are ignored |

## Verification
The hardest situations to reach are the ones that collide with a command: a store in the same cycle as a checkpoint, requests in the same cycle as a rollback, and traffic that keeps arriving while the rollback runs. The bench drives all of these on purpose. It holds a store to an untouched word and a checkpoint high for the whole busy window. It then checks two things at the ports: that the busy length matches the log that existed before the command, and that the untouched word kept its value. Repeated stores to already-logged words, and a store to every word, show at the ports that only first writes are logged.

// File: rtl/ulog_pkg.sv
package ulog_pkg;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_UNDO = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic mem_we;
        logic mem_from_log;
        logic rd_en;
        logic log_push;
        logic log_pop;
        logic log_clr;
        logic flag_set;
        logic flag_clr;
    } ulog_ctl_t;

    function automatic int unsigned words_of(int unsigned aw);
        return 32'd1 << aw;
    endfunction

endpackage

// File: rtl/ulog_mem.sv
module ulog_mem #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data
);
    localparam int WORDS = ulog_pkg::words_of(AW);

    logic [DW-1:0] words_q [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) words_q[i] <= '0;
        end else if (we) begin
            words_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= words_q[raddr];
    end

    assign peek_data = words_q[peek_addr];
endmodule

// File: rtl/ulog_flags.sv
module ulog_flags #(
    parameter int AW = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                clr_all,
    input  logic                                set_en,
    input  logic [AW-1:0]                       set_idx,
    output logic [ulog_pkg::words_of(AW)-1:0]   flags
);
    localparam int WORDS = ulog_pkg::words_of(AW);

    for (genvar g = 0; g < WORDS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                                flags[g] <= 1'b0;
            else if (set_en && set_idx == AW'(g))   flags[g] <= 1'b1;
            else if (clr_all)                       flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/ulog_log.sv
module ulog_log #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          clr,
    output logic [AW-1:0] top_addr,
    output logic [DW-1:0] top_data,
    output logic [AW:0]   count
);
    localparam int WORDS = ulog_pkg::words_of(AW);

    logic [AW-1:0] addr_q [WORDS];
    logic [DW-1:0] data_q [WORDS];
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] top_idx;
    logic [AW:0]   count_nxt;

    assign wr_idx  = clr ? '0 : count[AW-1:0];
    assign top_idx = count[AW-1:0] - AW'(1);

    always_comb begin
        count_nxt = count;
        if (clr)       count_nxt = push ? (AW+1)'(1) : '0;
        else if (push) count_nxt = count + (AW+1)'(1);
        else if (pop)  count_nxt = count - (AW+1)'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_nxt;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_idx] <= push_addr;
            data_q[wr_idx] <= push_data;
        end
    end

    assign top_addr = addr_q[top_idx];
    assign top_data = data_q[top_idx];
endmodule

// File: rtl/ulog_seq.sv
module ulog_seq #(
    parameter int AW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               ckpt,
    input  logic               rollback,
    input  logic               flag_hit,
    input  logic [AW:0]        log_cnt,
    output ulog_pkg::ulog_ctl_t ctl,
    output logic               undo_active
);
    import ulog_pkg::*;

    seq_state_e state_q;
    logic idle, accept, store, take_ck, undo_last, undo_step;

    assign idle      = (state_q == SQ_IDLE);
    assign accept    = idle && !rollback && req_valid;
    assign store     = accept && req_write;
    assign take_ck   = idle && !rollback && ckpt;
    assign undo_step = !idle && (log_cnt != '0);
    assign undo_last = !idle && (log_cnt <= (AW+1)'(1));

    always_comb begin
        ctl              = '0;
        ctl.rd_en        = accept && !req_write;
        ctl.log_push     = store && (take_ck || !flag_hit);
        ctl.log_pop      = undo_step;
        ctl.log_clr      = take_ck || undo_last;
        ctl.flag_set     = ctl.log_push;
        ctl.flag_clr     = take_ck || undo_last;
        ctl.mem_we       = store || undo_step;
        ctl.mem_from_log = !idle;
    end

    always_ff @(posedge clk) begin
        if (rst)                       state_q <= SQ_IDLE;
        else if (idle && rollback)     state_q <= SQ_UNDO;
        else if (undo_last)            state_q <= SQ_IDLE;
    end

    assign undo_active = !idle;
endmodule

// File: rtl/ulog_ckpt_unit.sv
module ulog_ckpt_unit #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ckpt,
    input  logic          rollback,
    output logic [DW-1:0] rsp_rdata,
    output logic          busy
);
    import ulog_pkg::*;
    localparam int WORDS = words_of(AW);

    ulog_ctl_t        ctl;
    logic [WORDS-1:0] flags;
    logic [AW:0]      log_cnt;
    logic [AW-1:0]    top_addr;
    logic [DW-1:0]    top_data;
    logic [DW-1:0]    old_data;
    logic [AW-1:0]    mem_waddr;
    logic [DW-1:0]    mem_wdata;

    ulog_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .ckpt(ckpt), .rollback(rollback), .flag_hit(flags[req_addr]),
        .log_cnt(log_cnt), .ctl(ctl), .undo_active(busy)
    );

    assign mem_waddr = ctl.mem_from_log ? top_addr : req_addr;
    assign mem_wdata = ctl.mem_from_log ? top_data : req_wdata;

    ulog_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst(rst), .we(ctl.mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .re(ctl.rd_en), .raddr(req_addr),
        .rdata(rsp_rdata), .peek_addr(req_addr), .peek_data(old_data)
    );

    ulog_flags #(.AW(AW)) u_flags (
        .clk(clk), .rst(rst), .clr_all(ctl.flag_clr), .set_en(ctl.flag_set),
        .set_idx(req_addr), .flags(flags)
    );

    ulog_log #(.AW(AW), .DW(DW)) u_log (
        .clk(clk), .rst(rst), .push(ctl.log_push), .push_addr(req_addr),
        .push_data(old_data), .pop(ctl.log_pop), .clr(ctl.log_clr),
        .top_addr(top_addr), .top_data(top_data), .count(log_cnt)
    );
endmodule

// File: rtl/ulog_ckpt_chk.sv
module ulog_ckpt_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_write,
    input logic          ckpt,
    input logic          rollback,
    input logic          busy,
    input logic [DW-1:0] rsp_rdata,
    input logic [AW:0]   log_cnt
);
    localparam int WORDS = ulog_pkg::words_of(AW);

    a_r7_busy_starts: assert property (@(posedge clk) disable iff (rst)
        (!busy && rollback) |=> busy);

    a_r7_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && log_cnt > (AW+1)'(1)) |=> busy);

    a_r9_undo_ends_empty: assert property (@(posedge clk) disable iff (rst)
        (busy && log_cnt <= (AW+1)'(1)) |=> (!busy && log_cnt == '0));

    a_r6_ckpt_empties: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rollback && ckpt && !(req_valid && req_write)) |=> (log_cnt == '0));

    a_r10_ckpt_store_logged: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rollback && ckpt && req_valid && req_write) |=> (log_cnt == (AW+1)'(1)));

    a_r3_log_grows_by_one: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rollback && !ckpt) |=>
        (log_cnt == $past(log_cnt) || log_cnt == $past(log_cnt) + (AW+1)'(1)));

    a_r8_rdata_held: assert property (@(posedge clk) disable iff (rst)
        (busy || rollback) |=> $stable(rsp_rdata));

    a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
        log_cnt <= (AW+1)'(WORDS));
endmodule

bind ulog_ckpt_unit ulog_ckpt_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .ckpt(ckpt), .rollback(rollback), .busy(busy), .rsp_rdata(rsp_rdata),
    .log_cnt(log_cnt)
);

// File: tb/sim_ulog_ckpt_unit.sv
`timescale 1ns/1ps
module sim_ulog_ckpt_unit;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int WORDS = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_write, ckpt, rollback;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [DW-1:0] rsp_rdata;
    logic          busy;

    int n_checks = 0;
    int n_fail   = 0;
    int m_mem [WORDS];
    int m_ck  [WORDS];
    bit m_fl  [WORDS];
    int m_n;

    always #5 clk = ~clk;

    ulog_ckpt_unit #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ckpt(ckpt),
        .rollback(rollback), .rsp_rdata(rsp_rdata), .busy(busy)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void m_ckpt();
        for (int i = 0; i < WORDS; i++) begin m_ck[i] = m_mem[i]; m_fl[i] = 0; end
        m_n = 0;
    endfunction

    function automatic void m_store(int a, int d);
        if (!m_fl[a]) begin m_fl[a] = 1; m_n++; end
        m_mem[a] = d;
    endfunction

    function automatic void m_undo();
        for (int i = 0; i < WORDS; i++) begin m_mem[i] = m_ck[i]; m_fl[i] = 0; end
        m_n = 0;
    endfunction

    task automatic idle_inputs();
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        ckpt = 0; rollback = 0;
    endtask

    task automatic do_store(int a, int d, bit with_ck);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = DW'(d); ckpt = with_ck;
        @(posedge clk); #1;
        idle_inputs();
        if (with_ck) m_ckpt();
        m_store(a, d);
    endtask

    task automatic do_ckpt();
        @(negedge clk);
        ckpt = 1;
        @(posedge clk); #1;
        idle_inputs();
        m_ckpt();
    endtask

    task automatic load(int a, output int v);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = AW'(a);
        @(posedge clk); #1;
        idle_inputs();
        v = int'(rsp_rdata);
    endtask

    task automatic load_chk(int a, string tag);
        int v;
        load(a, v);
        chk(tag, v, m_mem[a]);
    endtask

    task automatic verify_all(string tag);
        int v, bad;
        bad = 0;
        for (int i = 0; i < WORDS; i++) begin
            load(i, v);
            if (v != m_mem[i]) begin
                if (bad == 0) $display("  word %0d read %0d want %0d", i, v, m_mem[i]);
                bad++;
            end
        end
        chk(tag, bad, 0);
    endtask

    // mode 0: plain; 1: store and checkpoint held during busy; 2: store and checkpoint with the command
    task automatic do_rollback(string tag, int mode);
        int exp_len, n;
        exp_len = (m_n == 0) ? 1 : m_n;
        @(negedge clk);
        rollback = 1;
        if (mode != 0) begin
            req_valid = 1; req_write = 1; req_addr = AW'(9 - mode); req_wdata = 8'hAA; ckpt = 1;
        end
        @(posedge clk); #1;
        rollback = 0;
        if (mode != 1) idle_inputs();
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(posedge clk); #1;
        end
        idle_inputs();
        chk(tag, n, exp_len);
        m_undo();
    endtask

    initial begin
        #2_000_000;
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int v;
        idle_inputs();
        for (int i = 0; i < WORDS; i++) begin m_mem[i] = 0; m_ck[i] = 0; m_fl[i] = 0; end
        m_n = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 rdata", int'(rsp_rdata), 0);
        verify_all("R1 memory zero");
        do_rollback("R1 log empty after reset", 0);

        // R2 R3 R4 R5 worked example
        do_ckpt();
        do_store(0, 3, 0); do_store(1, 4, 0); do_store(0, 5, 0); do_store(2, 6, 0);
        load_chk(0, "R3 store addr0");
        load_chk(1, "R2 load addr1");
        load_chk(2, "R3 store addr2");
        repeat (3) @(posedge clk);
        #1 chk("R2 rdata held", int'(rsp_rdata), 6);
        do_rollback("R4 three entries", 0);
        verify_all("R5 restored to checkpoint");

        // R6 checkpoint clears log
        do_store(5, 7, 0);
        do_ckpt();
        do_store(5, 9, 0); do_store(6, 1, 0);
        do_rollback("R6 only post-checkpoint entries", 0);
        verify_all("R6 pre-checkpoint store kept");
        do_ckpt();
        do_rollback("R7 empty log one cycle", 0);

        // R9 restored state is new checkpoint
        do_store(7, 3, 0);
        do_rollback("R9 first rollback", 0);
        do_rollback("R9 second rollback one cycle", 0);
        verify_all("R9 second rollback no change");

        // R10 store with checkpoint
        do_store(4, 5, 0);
        do_store(3, 8, 0);
        do_store(3, 11, 1);
        do_store(3, 12, 0);
        do_rollback("R10 single entry", 0);
        verify_all("R10 store with checkpoint undone");

        // R8 ignored while busy
        do_ckpt();
        for (int i = 0; i < 4; i++) do_store(i, 20 + i, 0);
        do_rollback("R8 busy length with traffic", 1);
        verify_all("R8 busy traffic no effect");
        load(2, v);
        chk("R8 rdata after busy", v, m_mem[2]);

        // R11 rollback priority
        do_ckpt();
        do_store(10, 33, 0);
        do_rollback("R11 same-cycle checkpoint ignored", 2);
        verify_all("R11 same-cycle store ignored");

        // R12 full log
        do_ckpt();
        for (int i = 0; i < WORDS; i++) do_store(i, i + 1, 0);
        for (int i = 0; i < WORDS; i++) do_store(i, i + 100, 0);
        load_chk(15, "R12 second pass written");
        do_rollback("R12 full log length", 0);
        verify_all("R12 full restore");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule